// File: doc/BRIEF.md
# Short Training Preamble Detector

This block watches a stream of complex baseband samples and raises a one-cycle pulse when the input starts to repeat itself every 16 samples. That repetition is how the short training field at the head of an OFDM frame appears. The block works only while an upstream power trigger says that real signal activity is present. Silence can look self-similar, so the block ignores all input outside that window.

For each accepted sample the block multiplies the sample from 16 positions earlier by the complex conjugate of the new sample. It sums these products over a sliding window of 16 samples, and in the same window it keeps a running sum of the new samples' energy. It estimates the magnitude of the summed product with shifts and adds: the larger of the absolute real and imaginary parts, plus one quarter of the smaller. A sample passes when that estimate is greater than three quarters of the windowed energy. A run of passing samples forms a plateau. Detection is declared once the plateau is long enough, provided the in-phase component within the plateau was clearly positive in more than a quarter of its samples and clearly negative in more than a quarter. A plain DC level correlates well, so this sign test is what rejects it.

The plateau length comes from a small settings port. Software writes it as a 32-bit value at one fixed address. After detection the block stays silent until the power trigger has dropped and risen again.

Top module: `stp_detect`

## Requirements
- R1: Each correlation product pairs the sample received 16 accepted samples earlier with the conjugate of the new sample, and it is summed over the last 16 products together with the energy of the last 16 new samples. An input that repeats every 16 samples and has both signs in I is detected, with the pulse between P+16 and P+56 accepted samples after the burst starts, where P is the plateau length.
- R2: A sample passes only when max(|re|,|im|) + min(|re|,|im|)/4 of the summed product is strictly greater than (energy>>1)+(energy>>2). Uncorrelated pseudo-noise is never detected.
- R3: Detection needs P consecutive passing samples. A failing sample restarts the run. A burst whose passing run is shorter than P produces no pulse.
- R4: Over the current run, the count of samples with I>0 and the count with I<0 must each exceed the run length shifted right by two. A constant input (I=2000, Q=500) is never detected.
- R5: While the power trigger is low, all history is cleared and no pulse is produced, even with valid samples arriving.
- R6: The detect output is high for exactly one clock cycle. At most one pulse occurs per high period of the power trigger, and a later high period can produce a new one.
- R7: A write with the address equal to 6 loads the 32-bit plateau length. Writes to any other address leave it unchanged.
- R8: Reset sets the plateau length to 100 and holds the detect output low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| pwr_trig | input | 1 | High while signal activity is present; detection is enabled only then |
| smp_vld | input | 1 | Sample strobe |
| smp_re | input | 16 | In-phase sample, two's complement |
| smp_im | input | 16 | Quadrature sample, two's complement |
| cfg_we | input | 1 | Settings write strobe |
| cfg_addr | input | 8 | Settings address; 6 selects the plateau length |
| cfg_wdata | input | 32 | Settings write data |
| det_o | output | 1 | One-cycle pulse on preamble detection |

## Verification
The hardest case to reach is a run that breaks partway and then restarts. The windowed sums lag the input by up to 32 samples, so a break in the input does not show up as a failing sample right away. The stimulus sends 50 periodic samples, then 16 zero samples, then the periodic pattern again from phase zero. In that sequence the count reached before the gap is short of the plateau, but it would reach it soon after the restart if the run were not cleared. The pulse must therefore arrive no earlier than a full plateau after the restart. A pseudo-noise burst exercises the threshold failing repeatedly, and a DC burst passes the threshold while failing the sign test.

// File: rtl/stp_pkg.sv
package stp_pkg;

    localparam int SMP_W     = 16;
    localparam int LAG       = 16;
    localparam int WIN       = 16;
    localparam int ADDR_W    = 8;
    localparam int DATA_W    = 32;
    localparam int PLAT_ADDR = 6;
    localparam int PLAT_DEF  = 100;

    // Sign class of a sample's in-phase part; zero is neither.
    typedef struct packed {
        logic pos;
        logic neg;
    } sgn_t;

    // Whether the detector may still fire in the current trigger period.
    typedef enum logic {
        ST_ARMED = 1'b0,
        ST_SPENT = 1'b1
    } arm_t;

endpackage

// File: rtl/stp_cfg.sv
module stp_cfg #(
    parameter int ADDR_W    = stp_pkg::ADDR_W,
    parameter int DATA_W    = stp_pkg::DATA_W,
    parameter int PLAT_ADDR = stp_pkg::PLAT_ADDR,
    parameter int PLAT_DEF  = stp_pkg::PLAT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] plat_o
);

    localparam logic [ADDR_W-1:0] SEL  = ADDR_W'(PLAT_ADDR);
    localparam logic [DATA_W-1:0] INIT = DATA_W'(PLAT_DEF);

    logic hit;
    assign hit = we && (addr == SEL);

    always_ff @(posedge clk) begin
        if (rst)      plat_o <= INIT;
        else if (hit) plat_o <= wdata;
    end

    AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
        !hit |=> $stable(plat_o)); // R7

endmodule

// File: rtl/stp_corr.sv
module stp_corr
    import stp_pkg::*;
#(
    parameter int SMP_W = stp_pkg::SMP_W,
    parameter int LAG   = stp_pkg::LAG,
    parameter int WIN   = stp_pkg::WIN,
    localparam int PROD_W = 2*SMP_W + 1,
    localparam int SUM_W  = PROD_W + $clog2(WIN)
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic                    vld_i,
    input  logic signed [SMP_W-1:0] re_i,
    input  logic signed [SMP_W-1:0] im_i,
    output logic                    vld_o,
    output logic signed [SUM_W-1:0] re_o,
    output logic signed [SUM_W-1:0] im_o,
    output logic [SUM_W-1:0]        eng_o,
    output sgn_t                    sg_o
);

    typedef struct packed {
        logic signed [SMP_W-1:0] re;
        logic signed [SMP_W-1:0] im;
    } tap_t;

    typedef struct packed {
        logic signed [PROD_W-1:0] re;
        logic signed [PROD_W-1:0] im;
        logic signed [PROD_W-1:0] en;
    } prod_t;

    function automatic logic signed [PROD_W-1:0] mul(
        input logic signed [SMP_W-1:0] a,
        input logic signed [SMP_W-1:0] b
    );
        logic signed [2*SMP_W-1:0] m;
        m = a * b;
        return {m[2*SMP_W-1], m};
    endfunction

    function automatic logic signed [SUM_W-1:0] ext(input logic signed [PROD_W-1:0] x);
        return {{(SUM_W-PROD_W){x[PROD_W-1]}}, x};
    endfunction

    logic  clr;
    tap_t  cur;
    tap_t  line [LAG];
    prod_t prod_c;
    prod_t p_q;
    logic  p_vld;
    sgn_t  p_sg;
    prod_t hist [WIN];
    logic signed [SUM_W-1:0] s_re, s_im, s_en;

    assign clr = rst || !en;
    assign cur = '{re: re_i, im: im_i};

    // Lag line: newest sample in tap 0, the one LAG samples back leaves tap LAG-1.
    for (genvar g = 0; g < LAG; g++) begin : g_lag
        if (g == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (clr)        line[g] <= '0;
                else if (vld_i) line[g] <= cur;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (clr)        line[g] <= '0;
                else if (vld_i) line[g] <= line[g-1];
            end
        end
    end

    // old * conj(new) and |new|^2
    always_comb begin
        prod_c.re = mul(line[LAG-1].re, cur.re) + mul(line[LAG-1].im, cur.im);
        prod_c.im = mul(line[LAG-1].im, cur.re) - mul(line[LAG-1].re, cur.im);
        prod_c.en = mul(cur.re, cur.re) + mul(cur.im, cur.im);
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            p_vld <= 1'b0;
            p_q   <= '0;
            p_sg  <= '0;
        end else begin
            p_vld <= vld_i;
            if (vld_i) begin
                p_q  <= prod_c;
                p_sg <= '{pos: !re_i[SMP_W-1] && (|re_i), neg: re_i[SMP_W-1]};
            end
        end
    end

    // Product history for the sliding window.
    for (genvar h = 0; h < WIN; h++) begin : g_win
        if (h == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (clr)        hist[h] <= '0;
                else if (p_vld) hist[h] <= p_q;
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (clr)        hist[h] <= '0;
                else if (p_vld) hist[h] <= hist[h-1];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (clr) begin
            s_re  <= '0;
            s_im  <= '0;
            s_en  <= '0;
            vld_o <= 1'b0;
            sg_o  <= '0;
        end else begin
            vld_o <= p_vld;
            if (p_vld) begin
                s_re <= s_re + ext(p_q.re) - ext(hist[WIN-1].re);
                s_im <= s_im + ext(p_q.im) - ext(hist[WIN-1].im);
                s_en <= s_en + ext(p_q.en) - ext(hist[WIN-1].en);
                sg_o <= p_sg;
            end
        end
    end

    assign re_o  = s_re;
    assign im_o  = s_im;
    assign eng_o = s_en;

    AST_ENG_NONNEG: assert property (@(posedge clk) disable iff (rst)
        !s_en[SUM_W-1]); // R1

    AST_IDLE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        !en |=> (s_en == '0) && !vld_o); // R5

endmodule

// File: rtl/stp_mag.sv
module stp_mag
    import stp_pkg::*;
#(
    parameter int IN_W = 37
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   en,
    input  logic                   vld_i,
    input  logic signed [IN_W-1:0] re_i,
    input  logic signed [IN_W-1:0] im_i,
    input  logic [IN_W-1:0]        eng_i,
    input  sgn_t                   sg_i,
    output logic                   vld_o,
    output logic [IN_W:0]          mag_o,
    output logic [IN_W-1:0]        eng_o,
    output sgn_t                   sg_o
);

    localparam int DEPTH = 3;

    typedef struct packed {
        logic            vld;
        logic [IN_W-1:0] eng;
        sgn_t            sg;
    } side_t;

    side_t           side [DEPTH];
    logic [IN_W-1:0] a_re, a_im;   // stage 1
    logic [IN_W-1:0] mx, mn;       // stage 2
    logic            clr;

    assign clr = rst || !en;

    always_ff @(posedge clk) begin
        if (clr) begin
            for (int k = 0; k < DEPTH; k++) side[k] <= '0;
            a_re  <= '0;
            a_im  <= '0;
            mx    <= '0;
            mn    <= '0;
            mag_o <= '0;
        end else begin
            side[0] <= '{vld: vld_i, eng: eng_i, sg: sg_i};
            for (int k = 1; k < DEPTH; k++) side[k] <= side[k-1];
            a_re  <= re_i[IN_W-1] ? IN_W'(-re_i) : IN_W'(re_i);
            a_im  <= im_i[IN_W-1] ? IN_W'(-im_i) : IN_W'(im_i);
            mx    <= (a_re >= a_im) ? a_re : a_im;
            mn    <= (a_re >= a_im) ? a_im : a_re;
            mag_o <= {1'b0, mx} + {3'b000, mn[IN_W-1:2]};
        end
    end

    assign vld_o = side[DEPTH-1].vld;
    assign eng_o = side[DEPTH-1].eng;
    assign sg_o  = side[DEPTH-1].sg;

    AST_MAG_ORDER: assert property (@(posedge clk) disable iff (rst || !en)
        mx >= mn); // R2

endmodule

// File: rtl/stp_plateau.sv
module stp_plateau
    import stp_pkg::*;
#(
    parameter int MAG_W = 38,
    parameter int ENG_W = 37,
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic             vld_i,
    input  logic [MAG_W-1:0] mag_i,
    input  logic [ENG_W-1:0] eng_i,
    input  sgn_t             sg_i,
    input  logic [CNT_W-1:0] min_plat,
    output logic             det_o
);

    logic [ENG_W-1:0] thr;
    logic             pass;
    logic [CNT_W-1:0] cnt_q, pos_q, neg_q;
    logic [CNT_W-1:0] cnt_n, pos_n, neg_n, quarter;
    logic             hit;
    arm_t             arm_q;

    // 0.75 * energy from two shifts
    assign thr  = (eng_i >> 1) + (eng_i >> 2);
    assign pass = mag_i > MAG_W'(thr);

    always_comb begin
        cnt_n   = cnt_q + 1'b1;
        pos_n   = pos_q + CNT_W'(sg_i.pos);
        neg_n   = neg_q + CNT_W'(sg_i.neg);
        quarter = cnt_n >> 2;
        hit     = (cnt_n >= min_plat) && (pos_n > quarter) && (neg_n > quarter);
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt_q <= '0;
            pos_q <= '0;
            neg_q <= '0;
            arm_q <= ST_ARMED;
            det_o <= 1'b0;
        end else begin
            det_o <= 1'b0;
            if (vld_i && arm_q == ST_ARMED) begin
                if (pass && hit) begin
                    det_o <= 1'b1;
                    arm_q <= ST_SPENT;
                    cnt_q <= '0;
                    pos_q <= '0;
                    neg_q <= '0;
                end else if (pass) begin
                    cnt_q <= cnt_n;
                    pos_q <= pos_n;
                    neg_q <= neg_n;
                end else begin
                    cnt_q <= '0;
                    pos_q <= '0;
                    neg_q <= '0;
                end
            end
        end
    end

    AST_PASS_FLOOR: assert property (@(posedge clk) disable iff (rst)
        pass |-> (MAG_W'(mag_i) > MAG_W'(eng_i >> 1))); // R2

    AST_RUN_RESTART: assert property (@(posedge clk) disable iff (rst)
        (en && vld_i && arm_q == ST_ARMED && !pass) |=> (cnt_q == '0)); // R3

    AST_SIGN_BOUND: assert property (@(posedge clk) disable iff (rst)
        ({1'b0, pos_q} + {1'b0, neg_q}) <= {1'b0, cnt_q}); // R4

    AST_GATED_QUIET: assert property (@(posedge clk) disable iff (rst)
        !en |=> !det_o); // R5

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        det_o |=> !det_o); // R6

    AST_SPENT_QUIET: assert property (@(posedge clk) disable iff (rst)
        (arm_q == ST_SPENT && en) |=> !det_o); // R6

endmodule

// File: rtl/stp_detect.sv
module stp_detect
    import stp_pkg::*;
#(
    parameter int SMP_W     = stp_pkg::SMP_W,
    parameter int LAG       = stp_pkg::LAG,
    parameter int WIN       = stp_pkg::WIN,
    parameter int ADDR_W    = stp_pkg::ADDR_W,
    parameter int DATA_W    = stp_pkg::DATA_W,
    parameter int PLAT_ADDR = stp_pkg::PLAT_ADDR,
    parameter int PLAT_DEF  = stp_pkg::PLAT_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pwr_trig,
    input  logic              smp_vld,
    input  logic [SMP_W-1:0]  smp_re,
    input  logic [SMP_W-1:0]  smp_im,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [DATA_W-1:0] cfg_wdata,
    output logic              det_o
);

    localparam int PROD_W = 2*SMP_W + 1;
    localparam int SUM_W  = PROD_W + $clog2(WIN);
    localparam int MAG_W  = SUM_W + 1;

    logic [DATA_W-1:0]       plat;
    logic                    c_vld;
    logic signed [SUM_W-1:0] c_re, c_im;
    logic [SUM_W-1:0]        c_eng;
    sgn_t                    c_sg;
    logic                    m_vld;
    logic [MAG_W-1:0]        m_mag;
    logic [SUM_W-1:0]        m_eng;
    sgn_t                    m_sg;

    stp_cfg #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PLAT_ADDR(PLAT_ADDR), .PLAT_DEF(PLAT_DEF)
    ) u_cfg (
        .clk(clk), .rst(rst), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .plat_o(plat)
    );

    stp_corr #(.SMP_W(SMP_W), .LAG(LAG), .WIN(WIN)) u_corr (
        .clk(clk), .rst(rst), .en(pwr_trig), .vld_i(smp_vld),
        .re_i($signed(smp_re)), .im_i($signed(smp_im)),
        .vld_o(c_vld), .re_o(c_re), .im_o(c_im), .eng_o(c_eng), .sg_o(c_sg)
    );

    stp_mag #(.IN_W(SUM_W)) u_mag (
        .clk(clk), .rst(rst), .en(pwr_trig), .vld_i(c_vld),
        .re_i(c_re), .im_i(c_im), .eng_i(c_eng), .sg_i(c_sg),
        .vld_o(m_vld), .mag_o(m_mag), .eng_o(m_eng), .sg_o(m_sg)
    );

    stp_plateau #(.MAG_W(MAG_W), .ENG_W(SUM_W), .CNT_W(DATA_W)) u_plat (
        .clk(clk), .rst(rst), .en(pwr_trig), .vld_i(m_vld),
        .mag_i(m_mag), .eng_i(m_eng), .sg_i(m_sg), .min_plat(plat),
        .det_o(det_o)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        $past(rst) |-> !det_o); // R8

endmodule

// File: tb/sim_stp_detect.sv
module sim_stp_detect;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        pwr_trig = 1'b0;
    logic        smp_vld = 1'b0;
    logic [15:0] smp_re = '0;
    logic [15:0] smp_im = '0;
    logic        cfg_we = 1'b0;
    logic [7:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic        det_o;

    always #10 clk = ~clk;   // 50 MHz

    stp_detect u0 (
        .clk(clk), .rst(rst), .pwr_trig(pwr_trig), .smp_vld(smp_vld),
        .smp_re(smp_re), .smp_im(smp_im), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .det_o(det_o)
    );

    // kind: 0 periodic, 1 DC, 2 periodic with trigger low, 3 pseudo-noise, 4 zeros
    typedef struct packed {
        logic [2:0]  kind;
        logic [15:0] plat;
        logic [15:0] len;
        logic        exp;
        logic [15:0] lo;
        logic [15:0] hi;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VEC [NV] = '{
        '{3'd0, 16'd100, 16'd400, 1'b1, 16'd116, 16'd156},  // R1 R6
        '{3'd1, 16'd100, 16'd400, 1'b0, 16'd0,   16'd0  },  // R4
        '{3'd0, 16'd40,  16'd200, 1'b1, 16'd56,  16'd96 },  // R7 R6 rearm
        '{3'd2, 16'd40,  16'd200, 1'b0, 16'd0,   16'd0  },  // R5
        '{3'd1, 16'd20,  16'd200, 1'b0, 16'd0,   16'd0  },  // R4
        '{3'd0, 16'd200, 16'd300, 1'b1, 16'd216, 16'd256},  // R3
        '{3'd0, 16'd300, 16'd300, 1'b0, 16'd0,   16'd0  },  // R3
        '{3'd3, 16'd100, 16'd400, 1'b0, 16'd0,   16'd0  }   // R2
    };
    localparam string VTAG [NV] = '{"R1", "R4", "R7", "R5", "R4", "R3", "R3", "R2"};

    int   n_chk = 0;
    int   n_bad = 0;
    int   scnt = 0;
    int   n_det = 0;
    int   first_at = -1;
    int   ph = 0;
    logic [15:0] lfsr = 16'hACE1;
    bit   done = 1'b0;

    always @(negedge clk) begin
        if (!rst && det_o) begin
            if (n_det == 0) first_at = scnt;
            n_det++;
        end
    end

    task automatic chk(input string tag, input bit ok, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] step_lfsr(input logic [15:0] x);
        logic [15:0] y;
        y = x ^ (x << 7);
        y = y ^ (y >> 9);
        y = y ^ (y << 8);
        return y;
    endfunction

    task automatic gen(input int kind);
        int k;
        k = ph % 16;
        case (kind)
            0, 2: begin
                smp_re = (k < 8) ? 16'(2000 + 150*k) : 16'(-(1800 + 90*k));
                smp_im = 16'((k % 4) * 500 - 700);
            end
            1: begin
                smp_re = 16'd2000;
                smp_im = 16'd500;
            end
            3: begin
                lfsr   = step_lfsr(lfsr);
                smp_re = 16'($signed(lfsr) >>> 2);
                lfsr   = step_lfsr(lfsr);
                smp_im = 16'($signed(lfsr) >>> 2);
            end
            default: begin
                smp_re = '0;
                smp_im = '0;
            end
        endcase
        ph++;
    endtask

    task automatic drive(input int kind, input int n);
        for (int t = 0; t < n; t++) begin
            @(posedge clk); #2;
            gen(kind);
            smp_vld = 1'b1;
            scnt++;
        end
    endtask

    task automatic idle(input int n);
        @(posedge clk); #2;
        smp_vld = 1'b0;
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic cfg_write(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #2;
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk); #2;
        cfg_we = 1'b0;
    endtask

    task automatic start_burst(input bit trig);
        @(posedge clk); #2;
        scnt = 0; n_det = 0; first_at = -1; ph = 0;
        pwr_trig = trig;
    endtask

    task automatic end_burst;
        idle(12);
        pwr_trig = 1'b0;
        idle(4);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #2 rst = 1'b0;
        @(negedge clk);
        chk("R8 reset detect low", det_o == 1'b0, det_o, 0);

        for (int v = 0; v < NV; v++) begin
            cfg_write(8'd6, 32'(VEC[v].plat));
            start_burst(VEC[v].kind != 3'd2);
            drive(int'(VEC[v].kind), int'(VEC[v].len));
            end_burst();
            chk(VTAG[v], n_det == int'(VEC[v].exp), n_det, int'(VEC[v].exp));
            if (VEC[v].exp)
                chk(VTAG[v], first_at >= int'(VEC[v].lo) && first_at <= int'(VEC[v].hi),
                    first_at, int'(VEC[v].lo));
        end

        // R7: a write to another address leaves the plateau length at 40
        cfg_write(8'd6, 32'd40);
        cfg_write(8'd7, 32'd5);
        start_burst(1'b1);
        drive(0, 200);
        end_burst();
        chk("R7 other address ignored", n_det == 1 && first_at >= 56 && first_at <= 96,
            first_at, 56);

        // R3: a run broken by a gap must restart from zero
        cfg_write(8'd6, 32'd60);
        start_burst(1'b1);
        drive(0, 50);
        drive(4, 16);
        ph = 0;
        drive(0, 200);
        end_burst();
        chk("R3 restart count", n_det, 1, 1);
        chk("R3 restart timing", first_at >= 142 && first_at <= 182, first_at, 142);

        // R6: trigger held for a long stream gives exactly one pulse
        cfg_write(8'd6, 32'd30);
        start_burst(1'b1);
        drive(0, 600);
        end_burst();
        chk("R6 single pulse", n_det == 1, n_det, 1);

        // R8: reset restores plateau length 100
        @(posedge clk); #2 rst = 1'b1;
        repeat (2) @(posedge clk);
        #2 rst = 1'b0;
        start_burst(1'b1);
        drive(0, 400);
        end_burst();
        chk("R8 default plateau", n_det == 1 && first_at >= 116 && first_at <= 156,
            first_at, 116);

        done = 1'b1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule